// File: doc/BRIEF.md
# Interrupt Source Controller

This block is the source side of a two-layer interrupt scheme. It owns a set of interrupt lines. Each line is set once to one of two kinds. An edge source fires on a rising edge of its line. A level source stays active for as long as its line is high. Every source holds a target server number and a priority. The all-ones priority means the source is masked. The block turns line activity into delivery requests for a downstream presenter. Each request carries a global source number, a priority and a server.

The presenter answers through three inputs. A reject input hands a delivered source back. An end-of-interrupt input retires a level source. A resend pulse asks the block to re-examine every source. That re-examination walks the sources one per clock cycle.

Requests leave the block through a single registered slot with a valid/ready handshake. Sources waiting for that slot are marked as queued inside the block. They are granted lowest index first. A configuration write port sets the server and priority of one source. A kind write port sets the type of a source, and the type survives the synchronous reset.

Top module: `isc_source_ctrl`

## Requirements
- R1: After reset no request is presented and `kind_err` is low. Every source is masked with all-ones priority and server 0, and all status is cleared, which includes pending-while-masked, rejected, sent and queued. A source's kind is not changed by reset.
- R2: The first kind write to a source sets it: `kind_wr_level`=1 makes it a level source and 0 makes it an edge source. A later kind write to the same source is ignored, and `kind_err` is high for exactly the cycle after that write. A source that was never given a kind produces no requests.
- R3: A rising edge on an unmasked edge source produces one request. That request has `dlv_num` = BASE + index and carries the source's priority and server.
- R4: A rising edge on a masked edge source produces no request and records pending-while-masked. A later configuration write that gives the source a priority other than all-ones clears the record and delivers with the new priority and server.
- R5: A reject of an edge source marks it rejected, and nothing is redelivered until a resend. When the resend visits a rejected source it clears the mark. It redelivers the source once if the source is unmasked.
- R6: A level source sends only when it is unmasked, its line is high and its sent flag is clear, and sending sets the flag. The rule is evaluated when the line changes, when the source is configured, and when a resend visits it. A resend therefore redelivers nothing while the flag is set or while the line is low.
- R7: A reject or an end-of-interrupt clears a level source's sent flag but triggers no delivery by itself. An end-of-interrupt has no effect on an edge source.
- R8: A resend pulse starts a scan one cycle later that visits source i in the i-th following cycle. A resend pulse that arrives during a scan restarts it at source 0. A source visited in cycle k is presented two cycles after the pulse cycle plus its index, when the slot is free.
- R9: Only one request is outstanding. While `dlv_valid` is high and `dlv_ready` is low, the number, priority and server are held.
- R10: When several sources are queued together, the lowest index is presented first.
- R11: A configuration write that masks a queued source withdraws the request before it is presented. An edge source withdrawn this way keeps pending-while-masked and is delivered on unmask. A level source withdrawn this way has its sent flag cleared and sends again when it is unmasked while its line is still high.
- R12: A reject or end-of-interrupt whose number lies outside BASE to BASE+N_SRC-1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_line | input | N_SRC | Interrupt input lines, one per source |
| kind_wr_en | input | 1 | Kind write strobe |
| kind_wr_idx | input | IDX_W | Source index for the kind write |
| kind_wr_level | input | 1 | 1 = level source, 0 = edge source |
| kind_err | output | 1 | High the cycle after a repeated kind write |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_idx | input | IDX_W | Source index for the configuration write |
| cfg_wr_server | input | SRV_W | New target server |
| cfg_wr_prio | input | PRIO_W | New priority, all ones masks |
| dlv_valid | output | 1 | Delivery request present |
| dlv_ready | input | 1 | Presenter takes the request |
| dlv_num | output | NUM_W | Global source number |
| dlv_prio | output | PRIO_W | Request priority |
| dlv_server | output | SRV_W | Request target server |
| rej_valid | input | 1 | Reject strobe |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being retired |
| resend_go | input | 1 | Resend-all pulse |

## Verification
The bench targets the places where the two source kinds differ. For each kind it checks what follows a reject, an end-of-interrupt and a resend. A design that treated both kinds alike would redeliver a retired edge source, or drop a level source that is still held high.

It masks sources while their requests wait behind a stalled presenter. A design that ignored this would emit an all-ones priority, or lose the pending record.

It counts exact cycles from a resend pulse, including a restarted scan. A scan that ran in parallel or did not restart would deliver early. It also rejects numbers just outside the window. A decoder that only kept the low bits would wrongly retire or reject a real source.

// File: rtl/isc_pkg.sv
package isc_pkg;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_EDGE  = 2'd1,
    KIND_LEVEL = 2'd2
  } src_kind_e;

endpackage

// File: rtl/isc_src_slot.sv
module isc_src_slot
  import isc_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int SRV_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kind_wr,
  input  logic              kind_wr_level,
  output logic              typed,
  input  logic              line,
  input  logic              cfg_hit,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic              rej_hit,
  input  logic              eoi_hit,
  input  logic              scan_hit,
  input  logic              grant,
  output logic              queued,
  output logic [PRIO_W-1:0] prio,
  output logic [SRV_W-1:0]  server
);

  localparam logic [PRIO_W-1:0] MASKED = '1;

  // Kind is held across the synchronous reset; only the power-up value clears it.
  src_kind_e kind = KIND_NONE;

  logic [PRIO_W-1:0] prio_q, prio_n;
  logic [SRV_W-1:0]  srv_q, srv_n;
  logic line_q, mpend_q, rej_q, sent_q, que_q;
  logic mpend_n, rej_n, sent_n, que_n;
  logic open_n;

  always_ff @(posedge clk) begin
    if (kind_wr && kind == KIND_NONE)
      kind <= kind_wr_level ? KIND_LEVEL : KIND_EDGE;
  end

  assign typed = (kind != KIND_NONE);

  always_comb begin
    prio_n  = cfg_hit ? cfg_prio : prio_q;
    srv_n   = cfg_hit ? cfg_server : srv_q;
    open_n  = (prio_n != MASKED);
    mpend_n = mpend_q;
    rej_n   = rej_q;
    sent_n  = sent_q;
    que_n   = que_q & ~grant;
    unique case (kind)
      KIND_EDGE: begin
        if (line && !line_q) begin
          if (open_n) que_n = 1'b1;
          else        mpend_n = 1'b1;
        end
        if (cfg_hit && open_n && mpend_q) begin
          mpend_n = 1'b0;
          que_n   = 1'b1;
        end
        if (cfg_hit && !open_n && que_n) begin
          que_n   = 1'b0;
          mpend_n = 1'b1;
        end
        if (scan_hit && rej_q) begin
          rej_n = 1'b0;
          if (open_n) que_n = 1'b1;
        end
        if (rej_hit) rej_n = 1'b1;
      end
      KIND_LEVEL: begin
        if (rej_hit || eoi_hit) sent_n = 1'b0;
        if (cfg_hit && !open_n && que_n) begin
          que_n  = 1'b0;
          sent_n = 1'b0;
        end
        if ((line != line_q) || cfg_hit || scan_hit) begin
          if (open_n && line && !sent_n) begin
            sent_n = 1'b1;
            que_n  = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q  <= MASKED;
      srv_q   <= '0;
      line_q  <= 1'b0;
      mpend_q <= 1'b0;
      rej_q   <= 1'b0;
      sent_q  <= 1'b0;
      que_q   <= 1'b0;
    end else begin
      prio_q  <= prio_n;
      srv_q   <= srv_n;
      line_q  <= line;
      mpend_q <= mpend_n;
      rej_q   <= rej_n;
      sent_q  <= sent_n;
      que_q   <= que_n;
    end
  end

  assign queued = que_q;
  assign prio   = prio_q;
  assign server = srv_q;

endmodule

// File: rtl/isc_pick.sv
module isc_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        idx    = IDX_W'(i);
        any    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/isc_resend_scan.sv
module isc_resend_scan #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  output logic [N-1:0] hit
);

  logic             on_q;
  logic [IDX_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q  <= 1'b0;
      pos_q <= '0;
    end else if (go) begin
      on_q  <= 1'b1;
      pos_q <= '0;
    end else if (on_q) begin
      if (pos_q == IDX_W'(N - 1)) on_q <= 1'b0;
      else                       pos_q <= pos_q + 1'b1;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = on_q && (pos_q == IDX_W'(i));
  end

endmodule

// File: rtl/isc_source_ctrl.sv
module isc_source_ctrl #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 8,
  parameter int SRV_W  = 4,
  parameter int NUM_W  = 12,
  parameter int BASE   = 16,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_line,
  input  logic              kind_wr_en,
  input  logic [IDX_W-1:0]  kind_wr_idx,
  input  logic              kind_wr_level,
  output logic              kind_err,
  input  logic              cfg_wr_en,
  input  logic [IDX_W-1:0]  cfg_wr_idx,
  input  logic [SRV_W-1:0]  cfg_wr_server,
  input  logic [PRIO_W-1:0] cfg_wr_prio,
  output logic              dlv_valid,
  input  logic              dlv_ready,
  output logic [NUM_W-1:0]  dlv_num,
  output logic [PRIO_W-1:0] dlv_prio,
  output logic [SRV_W-1:0]  dlv_server,
  input  logic              rej_valid,
  input  logic [NUM_W-1:0]  rej_num,
  input  logic              eoi_valid,
  input  logic [NUM_W-1:0]  eoi_num,
  input  logic              resend_go
);

  localparam logic [NUM_W-1:0] BASE_N = NUM_W'(BASE);
  localparam logic [NUM_W-1:0] SPAN_N = NUM_W'(N_SRC);

  logic [N_SRC-1:0] typed, kind_sel, cfg_hit, rej_hit, eoi_hit, scan_hit;
  logic [N_SRC-1:0] queued, gnt, grant;
  logic [PRIO_W-1:0] prio_arr [N_SRC];
  logic [SRV_W-1:0]  srv_arr  [N_SRC];
  logic [NUM_W-1:0]  rej_off, eoi_off;
  logic              rej_in, eoi_in, load, any;
  logic [IDX_W-1:0]  pick_idx;

  // Global number window decode
  assign rej_off = rej_num - BASE_N;
  assign eoi_off = eoi_num - BASE_N;
  assign rej_in  = rej_valid && (rej_num >= BASE_N) && (rej_off < SPAN_N);
  assign eoi_in  = eoi_valid && (eoi_num >= BASE_N) && (eoi_off < SPAN_N);

  assign load  = !dlv_valid || dlv_ready;
  assign grant = load ? gnt : '0;

  isc_resend_scan #(.N(N_SRC), .IDX_W(IDX_W)) u_scan (
    .clk (clk),
    .rst (rst),
    .go  (resend_go),
    .hit (scan_hit)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign kind_sel[i] = kind_wr_en && (kind_wr_idx == IDX_W'(i));
    assign cfg_hit[i]  = cfg_wr_en && (cfg_wr_idx == IDX_W'(i));
    assign rej_hit[i]  = rej_in && (rej_off == NUM_W'(i));
    assign eoi_hit[i]  = eoi_in && (eoi_off == NUM_W'(i));

    isc_src_slot #(.PRIO_W(PRIO_W), .SRV_W(SRV_W)) u_slot (
      .clk           (clk),
      .rst           (rst),
      .kind_wr       (kind_sel[i]),
      .kind_wr_level (kind_wr_level),
      .typed         (typed[i]),
      .line          (src_line[i]),
      .cfg_hit       (cfg_hit[i]),
      .cfg_prio      (cfg_wr_prio),
      .cfg_server    (cfg_wr_server),
      .rej_hit       (rej_hit[i]),
      .eoi_hit       (eoi_hit[i]),
      .scan_hit      (scan_hit[i]),
      .grant         (grant[i]),
      .queued        (queued[i]),
      .prio          (prio_arr[i]),
      .server        (srv_arr[i])
    );
  end

  isc_pick #(.N(N_SRC), .IDX_W(IDX_W)) u_pick (
    .req (queued),
    .gnt (gnt),
    .idx (pick_idx),
    .any (any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_valid  <= 1'b0;
      dlv_num    <= '0;
      dlv_prio   <= '0;
      dlv_server <= '0;
      kind_err   <= 1'b0;
    end else begin
      kind_err <= |(kind_sel & typed);
      if (load) begin
        dlv_valid <= any;
        if (any) begin
          dlv_num    <= BASE_N + NUM_W'(pick_idx);
          dlv_prio   <= prio_arr[pick_idx];
          dlv_server <= srv_arr[pick_idx];
        end
      end
    end
  end

endmodule

// File: rtl/isc_source_ctrl_chk.sv
module isc_source_ctrl_chk #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 8,
  parameter int SRV_W  = 4,
  parameter int NUM_W  = 12,
  parameter int BASE   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              kind_wr_en,
  input logic              kind_err,
  input logic              dlv_valid,
  input logic              dlv_ready,
  input logic [NUM_W-1:0]  dlv_num,
  input logic [PRIO_W-1:0] dlv_prio,
  input logic [SRV_W-1:0]  dlv_server
);

  localparam logic [PRIO_W-1:0] MASKED = '1;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dlv_valid && !kind_err));

  assert_err_cause_R2: assert property (@(posedge clk) disable iff (rst)
    kind_err |-> $past(kind_wr_en));

  assert_num_window_R3: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> (dlv_num >= NUM_W'(BASE) && dlv_num < NUM_W'(BASE + N_SRC)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && !dlv_ready) |=>
      (dlv_valid && $stable(dlv_num) && $stable(dlv_prio) && $stable(dlv_server)));

  assert_never_masked_R11: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> (dlv_prio != MASKED));

endmodule

bind isc_source_ctrl isc_source_ctrl_chk #(
  .N_SRC(N_SRC), .PRIO_W(PRIO_W), .SRV_W(SRV_W), .NUM_W(NUM_W), .BASE(BASE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .kind_wr_en (kind_wr_en),
  .kind_err   (kind_err),
  .dlv_valid  (dlv_valid),
  .dlv_ready  (dlv_ready),
  .dlv_num    (dlv_num),
  .dlv_prio   (dlv_prio),
  .dlv_server (dlv_server)
);

// File: tb/test_isc_source_ctrl.sv
module test_isc_source_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int N_SRC = 8, PRIO_W = 8, SRV_W = 4, NUM_W = 12, BASE = 16;
  localparam int IDX_W = $clog2(N_SRC);
  localparam int OFF = 255;

  logic clk = 1'b0, rst = 1'b1;
  logic [N_SRC-1:0] src_line = '0;
  logic kind_wr_en = 0, kind_wr_level = 0, cfg_wr_en = 0;
  logic [IDX_W-1:0] kind_wr_idx = '0, cfg_wr_idx = '0;
  logic [SRV_W-1:0] cfg_wr_server = '0;
  logic [PRIO_W-1:0] cfg_wr_prio = '0;
  logic dlv_ready = 1'b1, rej_valid = 0, eoi_valid = 0, resend_go = 0;
  logic [NUM_W-1:0] rej_num = '0, eoi_num = '0;
  logic kind_err, dlv_valid;
  logic [NUM_W-1:0] dlv_num;
  logic [PRIO_W-1:0] dlv_prio;
  logic [SRV_W-1:0] dlv_server;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  isc_source_ctrl #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .SRV_W(SRV_W),
                    .NUM_W(NUM_W), .BASE(BASE)) i_isc_source_ctrl (
    .clk(clk), .rst(rst), .src_line(src_line),
    .kind_wr_en(kind_wr_en), .kind_wr_idx(kind_wr_idx), .kind_wr_level(kind_wr_level),
    .kind_err(kind_err), .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx),
    .cfg_wr_server(cfg_wr_server), .cfg_wr_prio(cfg_wr_prio),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_num(dlv_num),
    .dlv_prio(dlv_prio), .dlv_server(dlv_server), .rej_valid(rej_valid),
    .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend_go(resend_go)
  );

  function automatic int gnum(int idx);
    return BASE + idx;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_req(int idx, int pr, int sv, string tag);
    int n = 0;
    tick();
    while (!dlv_valid && n < 30) begin tick(); n++; end
    check(dlv_valid, {tag, " valid"}, int'(dlv_valid), 1);
    check(int'(dlv_num) == gnum(idx), {tag, " num"}, int'(dlv_num), gnum(idx));
    check(int'(dlv_prio) == pr, {tag, " prio"}, int'(dlv_prio), pr);
    check(int'(dlv_server) == sv, {tag, " server"}, int'(dlv_server), sv);
  endtask

  task automatic expect_none(int n, string tag);
    bit seen = 0;
    repeat (n) begin tick(); if (dlv_valid) seen = 1; end
    check(!seen, {tag, " no request"}, int'(seen), 0);
  endtask

  task automatic set_kind(int idx, bit lvl);
    tick(); kind_wr_en = 1; kind_wr_idx = IDX_W'(idx); kind_wr_level = lvl;
    tick(); kind_wr_en = 0;
  endtask

  task automatic cfg(int idx, int pr, int sv);
    tick(); cfg_wr_en = 1; cfg_wr_idx = IDX_W'(idx);
    cfg_wr_prio = PRIO_W'(pr); cfg_wr_server = SRV_W'(sv);
    tick(); cfg_wr_en = 0;
  endtask

  task automatic pulse(int idx);
    tick(); src_line[idx] = 1'b1;
    tick(); src_line[idx] = 1'b0;
  endtask

  task automatic reject(int num);
    tick(); rej_valid = 1; rej_num = NUM_W'(num);
    tick(); rej_valid = 0;
  endtask

  task automatic retire(int num);
    tick(); eoi_valid = 1; eoi_num = NUM_W'(num);
    tick(); eoi_valid = 0;
  endtask

  task automatic resend();
    tick(); resend_go = 1;
    tick(); resend_go = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed = $urandom(32'h00C0FFEE);
    int lat;
    repeat (3) tick();
    check(!dlv_valid, "R1 reset valid", int'(dlv_valid), 0);
    check(!kind_err, "R1 reset err", int'(kind_err), 0);
    rst = 0;

    // Kinds: 0..3 edge, 4..6 level, 7 never typed
    for (int i = 0; i < 4; i++) set_kind(i, 1'b0);
    check(!kind_err, "R2 first write no error", int'(kind_err), 0);
    for (int i = 4; i < 7; i++) set_kind(i, 1'b1);
    set_kind(0, 1'b1);
    check(kind_err, "R2 repeat write error", int'(kind_err), 1);
    tick();
    check(!kind_err, "R2 error one cycle", int'(kind_err), 0);

    // R1/R4: masked after reset, edge pending while masked
    pulse(1);
    expect_none(6, "R1 masked after reset");
    cfg(1, 5, 3);
    expect_req(1, 5, 3, "R4 unmask delivers");
    expect_none(6, "R4 single delivery");

    // R3: source 0 stays edge despite repeated kind write
    cfg(0, 2, 1);
    pulse(0);
    expect_req(0, 2, 1, "R3 first edge");
    pulse(0);
    expect_req(0, 2, 1, "R2 kind kept edge");

    // R2: untyped source
    cfg(7, 1, 1);
    pulse(7);
    expect_none(6, "R2 untyped source");

    // R5: reject then resend
    reject(gnum(1));
    expect_none(8, "R5 no redelivery before resend");
    resend();
    expect_req(1, 5, 3, "R5 resend redelivers");
    resend();
    expect_none(14, "R5 rejected cleared");

    // R6 / R7 level behaviour on source 4
    cfg(4, 9, 1);
    expect_none(4, "R6 line low no send");
    tick(); src_line[4] = 1'b1;
    expect_req(4, 9, 1, "R6 assert sends");
    resend();
    expect_none(14, "R6 sent blocks resend");
    retire(gnum(4));
    expect_none(6, "R7 eoi alone no send");
    resend();
    expect_req(4, 9, 1, "R7 eoi then resend");
    reject(gnum(4));
    resend();
    expect_req(4, 9, 1, "R7 reject then resend");
    retire(gnum(1));
    resend();
    expect_none(14, "R7 eoi no effect on edge");

    // R12: out-of-window reject/eoi
    reject(BASE + N_SRC);
    reject(BASE - 1);
    retire(BASE + N_SRC + 4);
    resend();
    expect_none(14, "R12 outside window ignored");
    retire(gnum(4));
    tick(); src_line[4] = 1'b0;
    resend();
    expect_none(14, "R6 deasserted no send");

    // R10 / R9: ordering and hold
    cfg(3, 4, 5);
    tick(); dlv_ready = 0; src_line[1] = 1; src_line[3] = 1;
    tick(); src_line[1] = 0; src_line[3] = 0;
    tick();
    for (int k = 0; k < 3; k++) begin
      tick();
      check(dlv_valid && int'(dlv_num) == gnum(1), "R10 lowest first",
            int'(dlv_num), gnum(1));
      check(int'(dlv_prio) == 5 && int'(dlv_server) == 3, "R9 held fields",
            int'(dlv_prio), 5);
    end
    dlv_ready = 1;
    expect_req(3, 4, 5, "R10 second source");
    expect_none(6, "R9 one each");

    // R11 edge withdraw
    tick(); dlv_ready = 0; src_line[1] = 1; src_line[3] = 1;
    tick(); src_line[1] = 0; src_line[3] = 0;
    tick();
    cfg(3, OFF, 5);
    check(dlv_valid && int'(dlv_num) == gnum(1), "R11 head kept", int'(dlv_num), gnum(1));
    dlv_ready = 1;
    expect_none(6, "R11 edge withdrawn");
    cfg(3, 4, 5);
    expect_req(3, 4, 5, "R11 edge on unmask");

    // R11 level withdraw
    cfg(5, 3, 6);
    expect_none(4, "R6 level low cfg");
    tick(); dlv_ready = 0; src_line[1] = 1;
    tick(); src_line[1] = 0;
    tick(); src_line[5] = 1;
    cfg(5, OFF, 6);
    check(dlv_valid && int'(dlv_num) == gnum(1), "R11 head kept level", int'(dlv_num), gnum(1));
    dlv_ready = 1;
    expect_none(6, "R11 level withdrawn");
    cfg(5, 3, 6);
    expect_req(5, 3, 6, "R11 level on unmask");
    retire(gnum(5));
    tick(); src_line[5] = 0;
    expect_none(4, "R6 level low");

    // R8 scan latency
    reject(gnum(3));
    tick(); resend_go = 1;
    tick(); resend_go = 0;
    lat = 1;
    while (!dlv_valid && lat < 20) begin tick(); lat++; end
    check(lat == 6, "R8 scan latency", lat, 6);
    expect_none(10, "R8 single");
    reject(gnum(3));
    tick(); resend_go = 1;
    tick(); resend_go = 0;
    tick(); resend_go = 1;
    tick(); resend_go = 0;
    lat = 1;
    while (!dlv_valid && lat < 20) begin tick(); lat++; end
    check(lat == 6, "R8 scan restart", lat, 6);
    expect_none(10, "R8 restart single");

    // Random edge-source traffic (R3, R4)
    for (int it = 0; it < 24; it++) begin
      int idx = int'($urandom % 4);
      int pr  = ($urandom % 4 == 0) ? OFF : int'($urandom % 255);
      int sv  = int'($urandom % 16);
      cfg(idx, pr, sv);
      pulse(idx);
      if (pr != OFF) begin
        expect_req(idx, pr, sv, "R3 random edge");
      end else begin
        int p2 = int'($urandom % 255);
        expect_none(5, "R4 random masked");
        cfg(idx, p2, sv);
        expect_req(idx, p2, sv, "R4 random unmask");
      end
      expect_none(3, "R3 random single");
    end

    // R1: reset clears status, keeps kind
    cfg(2, OFF, 0);
    pulse(2);
    tick(); rst = 1;
    repeat (2) tick();
    rst = 0;
    check(!dlv_valid, "R1 reset again", int'(dlv_valid), 0);
    cfg(2, 7, 2);
    expect_none(6, "R1 pending cleared");
    tick(); src_line[6] = 1;
    cfg(6, 8, 4);
    expect_req(6, 8, 4, "R1 level kind kept");
    tick(); src_line[6] = 0;
    cfg(2, 7, 2);
    pulse(2);
    expect_req(2, 7, 2, "R1 edge kind kept");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule